// File: doc/BRIEF.md
# Narrow-Bus Instruction Fetch Unit

This unit feeds a core whose instructions are 12 bits wide from a memory that returns one byte per access over an 8-bit data bus. Because 12 is not a multiple of 8, every instruction needs two bus beats. The unit issues two read strobes at consecutive byte addresses and collects the two returned bytes into a 16-bit holding word. It keeps the top 12 bits as the instruction and drops the last four.

The memory answers every strobe one cycle later, and the unit never stalls that answer. A stall input stops new strobes and freezes the program counter. A load input moves the counter to a new target and abandons any fetch that is half done. The core sees a 12-bit instruction word with a one-cycle valid pulse.

Top module: `narrow_fetch`

## Requirements
- R1: While reset is low and right after it, the program counter is 0, the valid output is low, and the first strobe after reset goes to byte address 0.
- R2: Each strobe advances the byte address by exactly 1, wrapping modulo 2^16, so each instruction takes two strobes at consecutive addresses and the program counter advances by 2 per instruction.
- R3: The byte on the read data input in the cycle after a strobe is the byte captured for that strobe. Data present in any other cycle is never used.
- R4: The byte from the lower address of a pair becomes instruction bits [11:4]. Bits [7:4] of the byte from the higher address become instruction bits [3:0], and bits [3:0] of that byte are discarded.
- R5: The valid output is high for exactly one cycle per instruction, in the cycle after the second byte is captured. The instruction output holds its value until the next pulse.
- R6: With no stall and no load, a load in cycle c gives strobes in c+1 and c+2 and a valid pulse in c+4. After that a new instruction is delivered every 3 cycles.
- R7: While stall is high and load is low, no strobe is issued and the address holds its value. A strobe already issued still has its byte captured, and after release the fetch resumes with no instruction lost.
- R8: A load takes priority over stall and over any fetch in progress. No strobe is issued in the load cycle. The next strobe targets the load address, and a fetch cut short by the load never produces a valid pulse.
- R9: An instruction whose first byte sits at address 0xFFFF takes its second byte from address 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Holds the counter and blocks new strobes |
| pc_load_i | input | 1 | Loads the counter with the target and aborts the fetch in progress |
| pc_target_i | input | 16 | Byte address loaded on pc_load_i |
| mem_addr_o | output | 16 | Byte address of the current or next read |
| mem_rd_o | output | 1 | Read strobe; the data answers one cycle later |
| mem_data_i | input | 8 | Read data, valid the cycle after a strobe |
| instr_o | output | 12 | Assembled instruction |
| instr_valid_o | output | 1 | One-cycle pulse marking a new instruction |

## Verification
The cases that are hardest to reach from the ports are the ones where a control input lands while a byte is still on its way back from memory. One is a stall that starts in the cycle the first byte returns. The other is a load that arrives while the second byte is being returned. Both need exact knowledge of the fetch phase. The bench gets it by issuing a load first, which puts the unit in a known phase, and then raises stall or a second load a fixed number of cycles later. A memory model returns a filler byte in cycles with no strobe, so a capture in the wrong cycle shows up in the instruction value.

// File: rtl/nf_pkg.sv
package nf_pkg;
  typedef enum logic [1:0] {
    ST_REQ_HI = 2'd0,
    ST_REQ_LO = 2'd1,
    ST_WAIT   = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/nf_fetch_pc.sv
module nf_fetch_pc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (load_i) pc_q <= target_i;
    else if (adv_i)  pc_q <= pc_q + ADDR_W'(1);
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/nf_fetch_seq.sv
module nf_fetch_seq
  import nf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic load_i,
  output logic rd_o,
  output logic cap_hi_o,
  output logic cap_lo_o
);
  fetch_st_e st_q, st_d;
  logic      pend_q, pend_lo_q;

  always_comb begin
    rd_o     = (st_q != ST_WAIT) && !stall_i && !load_i;
    // a load drops any byte still in flight
    cap_hi_o = pend_q && !pend_lo_q && !load_i;
    cap_lo_o = pend_q &&  pend_lo_q && !load_i;
    st_d     = st_q;
    if (load_i)        st_d = ST_REQ_HI;
    else if (rd_o)     st_d = (st_q == ST_REQ_HI) ? ST_REQ_LO : ST_WAIT;
    else if (cap_lo_o) st_d = ST_REQ_HI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_REQ_HI;
      pend_q    <= 1'b0;
      pend_lo_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_q    <= rd_o;
      pend_lo_q <= rd_o && (st_q == ST_REQ_LO);
    end
  end

  // R3
  cap_hi_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hi_o |-> $past(rd_o));

  // R3
  cap_lo_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_lo_o |-> $past(rd_o));

  // R6
  wait_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |=> (st_q == ST_REQ_HI));
endmodule

// File: rtl/nf_assemble.sv
module nf_assemble #(
  parameter int BUS_W   = 8,
  parameter int INSTR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_hi_i,
  input  logic               cap_lo_i,
  input  logic [BUS_W-1:0]   data_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               valid_o
);
  localparam int HOLD_W = 2 * BUS_W;
  localparam int DROP_W = HOLD_W - INSTR_W;

  logic [BUS_W-1:0]   hi_q;
  logic [HOLD_W-1:0]  word;
  logic [INSTR_W-1:0] instr_q;
  logic               valid_q;

  assign word = {hi_q, data_i};

  generate
    if (DROP_W > 0) begin : g_drop
      logic [DROP_W-1:0] unused_nib;
      assign unused_nib = word[DROP_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      instr_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap_hi_i) hi_q <= data_i;
      if (cap_lo_i) instr_q <= word[HOLD_W-1 -: INSTR_W];
      valid_q <= cap_lo_i;
    end
  end

  assign instr_o = instr_q;
  assign valid_o = valid_q;

  // R5
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R5
  instr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(instr_q));
endmodule

// File: rtl/narrow_fetch.sv
module narrow_fetch #(
  parameter int ADDR_W  = 16,
  parameter int BUS_W   = 8,
  parameter int INSTR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic               pc_load_i,
  input  logic [ADDR_W-1:0]  pc_target_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_rd_o,
  input  logic [BUS_W-1:0]   mem_data_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o
);
  logic rd, cap_hi, cap_lo;

  nf_fetch_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (stall_i),
    .load_i   (pc_load_i),
    .rd_o     (rd),
    .cap_hi_o (cap_hi),
    .cap_lo_o (cap_lo)
  );

  nf_fetch_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (rd),
    .load_i   (pc_load_i),
    .target_i (pc_target_i),
    .pc_o     (mem_addr_o)
  );

  nf_assemble #(.BUS_W(BUS_W), .INSTR_W(INSTR_W)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_hi_i (cap_hi),
    .cap_lo_i (cap_lo),
    .data_i   (mem_data_i),
    .instr_o  (instr_o),
    .valid_o  (instr_valid_o)
  );

  assign mem_rd_o = rd;

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !pc_load_i) |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(1))));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !pc_load_i) |=> $stable(mem_addr_o));

  // R8
  load_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |=> (mem_addr_o == $past(pc_target_i)));

  // R8
  load_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_i |=> !instr_valid_o);
endmodule

// File: tb/narrow_fetch_tb_top.sv
module narrow_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        load = 1'b0;
  logic [15:0] target = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o;
  logic [7:0]  rdata = 8'hEE;
  logic [11:0] instr_o;
  logic        instr_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_addr = '0;
  logic [15:0] exp_pc   = '0;
  bit prev_valid = 1'b0;

  always #4 clk = ~clk;

  narrow_fetch dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .stall_i       (stall),
    .pc_load_i     (load),
    .pc_target_i   (target),
    .mem_addr_o    (mem_addr_o),
    .mem_rd_o      (mem_rd_o),
    .mem_data_i    (rdata),
    .instr_o       (instr_o),
    .instr_valid_o (instr_valid_o)
  );

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5B;
  endfunction

  // R4: first byte -> [11:4], high nibble of second byte -> [3:0]
  function automatic logic [11:0] exp_instr(input logic [15:0] a);
    logic [7:0] b1;
    b1 = mbyte(a + 16'd1);
    return {mbyte(a), b1[7:4]};
  endfunction

  // memory: one-cycle latency, filler byte when no strobe
  always @(posedge clk) rdata <= mem_rd_o ? mbyte(mem_addr_o) : 8'hEE;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stream monitor: R2 addresses, R4 content, R5 single pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_rd_o) begin
        chk(mem_addr_o == exp_addr, "R2 addr", 32'(mem_addr_o), 32'(exp_addr));
        exp_addr = exp_addr + 16'd1;
      end
      if (instr_valid_o) begin
        chk(instr_o == exp_instr(exp_pc), "R4 instr", 32'(instr_o), 32'(exp_instr(exp_pc)));
        chk(!prev_valid, "R5 pulse width", 32'(prev_valid), 32'd0);
        exp_pc = exp_pc + 16'd2;
      end
      prev_valid = instr_valid_o;
    end
  end

  task automatic do_load(input logic [15:0] t);
    @(posedge clk); #1;
    load = 1'b1; target = t;
    @(posedge clk); #1;
    load = 1'b0;
    exp_addr = t; exp_pc = t;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); n++;
      if (instr_valid_o) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(instr_valid_o == 1'b0, "R1 valid in reset", 32'(instr_valid_o), 32'd0);
    chk(mem_addr_o == 16'd0, "R1 pc in reset", 32'(mem_addr_o), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_rd_o && mem_addr_o == 16'd0, "R1 first strobe", 32'({mem_rd_o, mem_addr_o}), 32'h10000);
    repeat (3) @(negedge clk);
    chk(instr_valid_o == 1'b1, "R1 first instr timing", 32'(instr_valid_o), 32'd1);
    repeat (12) @(posedge clk);
  endtask

  task automatic t_cadence();
    int n;
    do_load(16'h1234);
    wait_valid(n);
    chk(n == 4, "R6 load to valid", 32'(n), 32'd4);
    wait_valid(n);
    chk(n == 3, "R6 cadence", 32'(n), 32'd3);
    wait_valid(n);
    chk(n == 3, "R6 cadence", 32'(n), 32'd3);
  endtask

  task automatic t_stall();
    int n;
    int strobes = 0;
    do_load(16'h0A40);
    // first strobe in this cycle; stall as its byte returns
    @(posedge clk); #1;
    stall = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (mem_rd_o) strobes++;
      chk(mem_addr_o == 16'h0A41, "R7 addr held", 32'(mem_addr_o), 32'h0A41);
    end
    chk(strobes == 0, "R7 no strobe", 32'(strobes), 32'd0);
    @(posedge clk); #1;
    stall = 1'b0;
    wait_valid(n);
    chk(instr_o == exp_instr(16'h0A40), "R7 resumed instr", 32'(instr_o), 32'(exp_instr(16'h0A40)));
  endtask

  task automatic t_load_abort();
    int n;
    do_load(16'h2000);
    @(posedge clk); #1;
    // second byte returns in the next cycle; load lands on it
    @(posedge clk); #1;
    load = 1'b1; target = 16'h3300;
    @(negedge clk);
    chk(!mem_rd_o, "R8 no strobe in load cycle", 32'(mem_rd_o), 32'd0);
    @(posedge clk); #1;
    load = 1'b0;
    exp_addr = 16'h3300; exp_pc = 16'h3300;
    wait_valid(n);
    chk(n == 4, "R8 aborted fetch silent", 32'(n), 32'd4);
    chk(instr_o == exp_instr(16'h3300), "R8 target instr", 32'(instr_o), 32'(exp_instr(16'h3300)));
  endtask

  task automatic t_load_over_stall();
    @(posedge clk); #1;
    stall = 1'b1; load = 1'b1; target = 16'h4567;
    @(posedge clk); #1;
    load = 1'b0;
    exp_addr = 16'h4567; exp_pc = 16'h4567;
    @(negedge clk);
    chk(mem_addr_o == 16'h4567, "R8 load beats stall", 32'(mem_addr_o), 32'h4567);
    @(posedge clk); #1;
    stall = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic t_wrap();
    int n;
    do_load(16'hFFFF);
    wait_valid(n);
    chk(instr_o == exp_instr(16'hFFFF), "R9 wrap instr", 32'(instr_o), 32'(exp_instr(16'hFFFF)));
    wait_valid(n);
    chk(instr_o == exp_instr(16'h0001), "R9 after wrap", 32'(instr_o), 32'(exp_instr(16'h0001)));
  endtask

  initial begin
    t_reset();
    t_cadence();
    t_stall();
    t_load_abort();
    t_load_over_stall();
    t_wrap();
    repeat (10) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule